// File: doc/BRIEF.md
# Stride Prefetch Stream Table

This block keeps a small set of active stride streams for a cache prefetcher. Each stream holds a current line address, a signed stride counted in cache lines, a valid bit and the cycle at which it was last used. A training unit outside the block asks for a new stream by giving a base line and a stride. The table then claims an entry and issues a short burst of startup prefetch line addresses on a valid/ready port. When the cache reports a demand access to a line that a stream covers, the stream moves forward by one stride and issues one more prefetch.

A combinational probe port reports whether a given line lies inside the recent window of any valid stream, and which stream that is. Streams stop at page boundaries unless page crossing is enabled. All addresses count lines, not bytes. The startup burst length is a parameter. It is clamped to the range 1 to 8.

Top module: `pf_stream_table`

## Requirements
- R1: After reset all streams are invalid, `busy` and `pf_valid` are low, and the probe reports no hit for any line.
- R2: An allocation takes the lowest-numbered invalid entry when one exists. Otherwise it takes the valid entry with the smallest last-use time, with the lower index winning a tie. Use time is a free-running cycle count.
- R3: An accepted allocation stores the base line, the stride (8-bit two's complement, sign-extended, with line arithmetic modulo 2^LINE_W) and the current time, and marks the entry valid. It then issues prefetches for base+1·stride, base+2·stride and so on, up to START_PF of them. The stream address is always the last line issued.
- R4: The page of a line is the line shifted right by log2(PAGE_LINES). Each candidate's page is compared with a reference page: the base's page for an allocation, or the stream address's page before the advance for a hit. If the pages differ and `cross_en` is 0, the stream is invalidated and no further prefetch is issued for it. If `cross_en` is 1, the sequence continues.
- R5: A hit whose line belongs to a valid stream acts on the lowest-indexed such stream. It refreshes that stream's use time and issues exactly one prefetch, for stream address + stride, which becomes the new stream address. A hit on a line that belongs to no stream is ignored.
- R6: A line belongs to a valid stream when it equals the stream address minus j·stride for some j in 0..START_PF-1. `probe_hit` and `probe_idx` report the lowest-indexed such stream in the same cycle as `probe_line`.
- R7: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_line` is unchanged. One prefetch leaves per handshake, and `pf_valid` is low in the cycle after a handshake.
- R8: `busy` rises in the cycle after an allocation, or after a hit on a member line. While `busy` is high, `alloc_valid` and `hit_valid` are ignored. With no command, an idle table stays idle.
- R9: When `alloc_valid` and `hit_valid` are both high in an idle cycle, only the allocation is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cross_en | input | 1 | 1 lets streams continue across page boundaries |
| alloc_valid | input | 1 | Request to start a new stream |
| alloc_line | input | LINE_W | Base line of the new stream |
| alloc_stride | input | STRIDE_W | Signed stride in lines |
| hit_valid | input | 1 | Demand access notification |
| hit_line | input | LINE_W | Line of the demand access |
| probe_line | input | LINE_W | Line to test for stream membership |
| probe_hit | output | 1 | Line is inside a valid stream's window |
| probe_idx | output | IDX_W | Lowest matching stream index |
| busy | output | 1 | Table is sequencing prefetches; commands are ignored |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
The properties assume that the consumer may hold `pf_ready` low for any number of cycles. They also assume that `cross_en` changes only while the table is idle, because the page decision is taken one cycle before the request is presented. The stimulus changes `cross_en` only between commands. It drives `pf_ready` at random so that requests are held. It also keeps commands asserted while `busy` is high, to show that they are dropped. Strides are kept nonzero, and bases sit in a narrow range so that page crossings, wrap-around below zero and victim replacement happen often.

// File: rtl/pf_stream_pkg.sv
// Package: shared sequencing state for the stride stream table.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pf_stream_pkg;

    // Sequencer state: idle, page check for the next candidate, present request.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CHECK = 2'd1,
        SEQ_SEND  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pf_victim_sel.sv
// Module: pf_victim_sel
// Picks the entry that an allocation overwrites. The lowest-numbered invalid
// entry wins. If none is invalid, the entry with the smallest use time wins,
// and the lower index wins a tie.
// Assumes use times are monotonic (the counter does not wrap within a run).
module pf_victim_sel #(
    parameter int N      = 4,
    parameter int TIME_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [N-1:0]             valid_vec,
    input  logic [N-1:0][TIME_W-1:0] use_time,
    output logic [IDX_W-1:0]         victim
);

    logic [IDX_W-1:0]  inv_idx;
    logic              any_inv;
    logic [IDX_W-1:0]  lru_idx;
    logic [TIME_W-1:0] lru_time;

    // Lowest-numbered invalid entry, scanned from the top down.
    always_comb begin
        inv_idx = '0;
        any_inv = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                inv_idx = IDX_W'(i);
                any_inv = 1'b1;
            end
        end
    end

    // Oldest use time; a strict compare keeps the lower index on ties.
    always_comb begin
        lru_idx  = '0;
        lru_time = use_time[0];
        for (int i = 1; i < N; i++) begin
            if (use_time[i] < lru_time) begin
                lru_time = use_time[i];
                lru_idx  = IDX_W'(i);
            end
        end
    end

    // Invalid entries take precedence over the LRU choice.
    always_comb begin
        victim = any_inv ? inv_idx : lru_idx;
    end

endmodule

// File: rtl/pf_member_match.sv
// Module: pf_member_match
// Tells whether a line lies in the trailing window of any valid stream. The
// window is the stream address minus j*stride for j = 0..DEPTH-1. Reports the
// lowest matching index.
// Assumes DEPTH is small (at most 8), so the subtract chain stays short.
module pf_member_match #(
    parameter int N        = 4,
    parameter int DEPTH    = 1,
    parameter int LINE_W   = 32,
    parameter int STRIDE_W = 8,
    parameter int IDX_W    = 2
) (
    input  logic [N-1:0]               valid_vec,
    input  logic [N-1:0][LINE_W-1:0]   addr_vec,
    input  logic [N-1:0][STRIDE_W-1:0] stride_vec,
    input  logic [LINE_W-1:0]          line,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx
);

    logic [N-1:0] per_hit;

    for (genvar g = 0; g < N; g++) begin : g_stream
        logic [LINE_W-1:0] step;
        logic [LINE_W-1:0] acc;
        logic              m;

        // Walk back across the window by repeated subtraction of the stride.
        always_comb begin
            step = {{(LINE_W - STRIDE_W){stride_vec[g][STRIDE_W-1]}}, stride_vec[g]};
            acc  = addr_vec[g];
            m    = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (acc == line) m = 1'b1;
                acc = acc - step;
            end
        end

        assign per_hit[g] = valid_vec[g] & m;
    end

    // Priority encode: the lowest-indexed matching stream wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (per_hit[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pf_stream_table.sv
// Module: pf_stream_table (top)
// Holds NUM_STREAMS stride streams. An allocation claims a victim entry and
// sends a burst of startup prefetches. A hit on a member line advances that
// stream by one stride and sends one prefetch. A page check runs one cycle
// before each request is presented. A combinational probe reports membership.
// Assumes cross_en changes only while busy is low, and that PAGE_LINES is a
// power of two smaller than 2**LINE_W.
module pf_stream_table
    import pf_stream_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int START_PF    = 1,
    parameter int LINE_W      = 32,
    parameter int STRIDE_W    = 8,
    parameter int PAGE_LINES  = 64,
    parameter int TIME_W      = 32,
    localparam int IDX_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cross_en,
    input  logic                alloc_valid,
    input  logic [LINE_W-1:0]   alloc_line,
    input  logic [STRIDE_W-1:0] alloc_stride,
    input  logic                hit_valid,
    input  logic [LINE_W-1:0]   hit_line,
    input  logic [LINE_W-1:0]   probe_line,
    output logic                probe_hit,
    output logic [IDX_W-1:0]    probe_idx,
    output logic                busy,
    output logic                pf_valid,
    input  logic                pf_ready,
    output logic [LINE_W-1:0]   pf_line
);

    localparam int SPF        = (START_PF > 8) ? 8 : ((START_PF < 1) ? 1 : START_PF);
    localparam int CNT_W      = $clog2(SPF + 1);
    localparam int PAGE_SHIFT = $clog2(PAGE_LINES);
    localparam int PAGE_W     = LINE_W - PAGE_SHIFT;

    // Stream table storage.
    logic [NUM_STREAMS-1:0]               ent_valid;
    logic [NUM_STREAMS-1:0][LINE_W-1:0]   ent_addr;
    logic [NUM_STREAMS-1:0][STRIDE_W-1:0] ent_stride;
    logic [NUM_STREAMS-1:0][TIME_W-1:0]   ent_time;

    // Sequencer state.
    seq_state_e        state;
    logic [IDX_W-1:0]  cur_idx;
    logic [LINE_W-1:0] cand;
    logic [PAGE_W-1:0] ref_page;
    logic [CNT_W-1:0]  remain;
    logic [TIME_W-1:0] now;

    logic [IDX_W-1:0]  victim;
    logic              hm_hit;
    logic [IDX_W-1:0]  hm_idx;
    logic              page_blocked;
    logic [LINE_W-1:0] alloc_step;
    logic [LINE_W-1:0] hit_step;
    logic [LINE_W-1:0] cur_step;

    pf_victim_sel #(
        .N      (NUM_STREAMS),
        .TIME_W (TIME_W),
        .IDX_W  (IDX_W)
    ) u_victim (
        .valid_vec (ent_valid),
        .use_time  (ent_time),
        .victim    (victim)
    );

    pf_member_match #(
        .N        (NUM_STREAMS),
        .DEPTH    (SPF),
        .LINE_W   (LINE_W),
        .STRIDE_W (STRIDE_W),
        .IDX_W    (IDX_W)
    ) u_hit_match (
        .valid_vec  (ent_valid),
        .addr_vec   (ent_addr),
        .stride_vec (ent_stride),
        .line       (hit_line),
        .hit        (hm_hit),
        .idx        (hm_idx)
    );

    pf_member_match #(
        .N        (NUM_STREAMS),
        .DEPTH    (SPF),
        .LINE_W   (LINE_W),
        .STRIDE_W (STRIDE_W),
        .IDX_W    (IDX_W)
    ) u_probe_match (
        .valid_vec  (ent_valid),
        .addr_vec   (ent_addr),
        .stride_vec (ent_stride),
        .line       (probe_line),
        .hit        (probe_hit),
        .idx        (probe_idx)
    );

    // Sign-extend the strides that can feed the next candidate.
    always_comb begin
        alloc_step = {{(LINE_W - STRIDE_W){alloc_stride[STRIDE_W-1]}}, alloc_stride};
        hit_step   = {{(LINE_W - STRIDE_W){ent_stride[hm_idx][STRIDE_W-1]}}, ent_stride[hm_idx]};
        cur_step   = {{(LINE_W - STRIDE_W){ent_stride[cur_idx][STRIDE_W-1]}}, ent_stride[cur_idx]};
    end

    // Page test of the pending candidate against the reference page.
    always_comb begin
        page_blocked = !cross_en && (cand[LINE_W-1:PAGE_SHIFT] != ref_page);
    end

    // Request port and busy flag, decoded from the state.
    always_comb begin
        pf_valid = (state == SEQ_SEND);
        pf_line  = cand;
        busy     = (state != SEQ_IDLE);
    end

    // Free-running use-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Command acceptance, page checks, prefetch sequencing and entry updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEQ_IDLE;
            ent_valid  <= '0;
            ent_addr   <= '0;
            ent_stride <= '0;
            ent_time   <= '0;
            cur_idx    <= '0;
            cand       <= '0;
            ref_page   <= '0;
            remain     <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (alloc_valid) begin
                        ent_valid[victim]  <= 1'b1;
                        ent_addr[victim]   <= alloc_line;
                        ent_stride[victim] <= alloc_stride;
                        ent_time[victim]   <= now;
                        cur_idx            <= victim;
                        cand               <= alloc_line + alloc_step;
                        ref_page           <= alloc_line[LINE_W-1:PAGE_SHIFT];
                        remain             <= CNT_W'(SPF);
                        state              <= SEQ_CHECK;
                    end else if (hit_valid && hm_hit) begin
                        ent_time[hm_idx] <= now;
                        cur_idx          <= hm_idx;
                        cand             <= ent_addr[hm_idx] + hit_step;
                        ref_page         <= ent_addr[hm_idx][LINE_W-1:PAGE_SHIFT];
                        remain           <= CNT_W'(1);
                        state            <= SEQ_CHECK;
                    end
                end
                SEQ_CHECK: begin
                    if (page_blocked) begin
                        ent_valid[cur_idx] <= 1'b0;
                        state              <= SEQ_IDLE;
                    end else begin
                        state <= SEQ_SEND;
                    end
                end
                SEQ_SEND: begin
                    if (pf_ready) begin
                        ent_addr[cur_idx] <= cand;
                        if (remain == CNT_W'(1)) begin
                            state <= SEQ_IDLE;
                        end else begin
                            remain <= remain - 1'b1;
                            cand   <= cand + cur_step;
                            state  <= SEQ_CHECK;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pf_stream_table_chk.sv
// Module: pf_stream_table_chk
// Temporal checks on the request port and the command interface of
// pf_stream_table. Attached to every instance by the bind below.
// Assumes the synchronous active-low reset of the top.
module pf_stream_table_chk #(
    parameter int LINE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              hit_valid,
    input logic              busy,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [LINE_W-1:0] pf_line
);

    // R7: a stalled request keeps its address and stays valid.
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));

    // R7: one prefetch per handshake, then a gap cycle.
    assert_gap_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready |=> !pf_valid);

    // R8: an allocation seen while idle starts sequencing.
    assert_alloc_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && alloc_valid |=> busy);

    // R8: an idle table with no command stays idle.
    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !alloc_valid && !hit_valid |=> !busy && !pf_valid);

endmodule

bind pf_stream_table pf_stream_table_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .hit_valid   (hit_valid),
    .busy        (busy),
    .pf_valid    (pf_valid),
    .pf_ready    (pf_ready),
    .pf_line     (pf_line)
);

// File: tb/pf_stream_table_tb.sv
// Bench for pf_stream_table. Directed corner cases and then seeded random
// commands, each compared against a behavioural table model in the bench.
module pf_stream_table_tb;

    localparam int N  = 4;
    localparam int S  = 3;
    localparam int LW = 20;
    localparam int SW = 8;
    localparam int PL = 16;
    localparam int PS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cross_en = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [LW-1:0] alloc_line = '0;
    logic [SW-1:0] alloc_stride = '0;
    logic          hit_valid = 1'b0;
    logic [LW-1:0] hit_line = '0;
    logic [LW-1:0] probe_line = '0;
    logic          probe_hit;
    logic [1:0]    probe_idx;
    logic          busy;
    logic          pf_valid;
    logic          pf_ready = 1'b0;
    logic [LW-1:0] pf_line;

    pf_stream_table #(
        .NUM_STREAMS (N),
        .START_PF    (S),
        .LINE_W      (LW),
        .STRIDE_W    (SW),
        .PAGE_LINES  (PL),
        .TIME_W      (32)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cross_en     (cross_en),
        .alloc_valid  (alloc_valid),
        .alloc_line   (alloc_line),
        .alloc_stride (alloc_stride),
        .hit_valid    (hit_valid),
        .hit_line     (hit_line),
        .probe_line   (probe_line),
        .probe_hit    (probe_hit),
        .probe_idx    (probe_idx),
        .busy         (busy),
        .pf_valid     (pf_valid),
        .pf_ready     (pf_ready),
        .pf_line      (pf_line)
    );

    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Bench model of the stream table.
    bit            m_valid [N];
    logic [LW-1:0] m_addr  [N];
    logic [SW-1:0] m_stride[N];
    int            m_time  [N];
    logic [LW-1:0] exp_q   [8];
    int            exp_n;

    function automatic logic [LW-1:0] ext(input logic [SW-1:0] s);
        return {{(LW - SW){s[SW-1]}}, s};
    endfunction

    function automatic logic [LW-1:0] pg(input logic [LW-1:0] l);
        return l >> PS;
    endfunction

    function automatic int m_victim();
        int lru = 0;
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        for (int i = 1; i < N; i++) if (m_time[i] < m_time[lru]) lru = i;
        return lru;
    endfunction

    function automatic int m_match(input logic [LW-1:0] l);
        logic [LW-1:0] a;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i]) begin
                a = m_addr[i];
                for (int j = 0; j < S; j++) begin
                    if (a == l) return i;
                    a = a - ext(m_stride[i]);
                end
            end
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Model of an allocation: fills exp_q with the expected startup lines.
    task automatic m_alloc(input logic [LW-1:0] base, input logic [SW-1:0] s, input bit x);
        int v;
        logic [LW-1:0] ln;
        v = m_victim();
        ln = base;
        m_valid[v] = 1; m_addr[v] = base; m_stride[v] = s; m_time[v] = cyc;
        exp_n = 0;
        for (int k = 0; k < S; k++) begin
            ln = ln + ext(s);
            if (!x && pg(ln) != pg(base)) begin
                m_valid[v] = 0;
                break;
            end
            exp_q[exp_n] = ln;
            exp_n++;
            m_addr[v] = ln;
        end
    endtask

    // Model of a hit: returns 1 when a stream matched.
    function automatic bit m_hit(input logic [LW-1:0] l, input bit x);
        int i;
        logic [LW-1:0] nl;
        exp_n = 0;
        i = m_match(l);
        if (i < 0) return 0;
        m_time[i] = cyc;
        nl = m_addr[i] + ext(m_stride[i]);
        if (!x && pg(nl) != pg(m_addr[i])) begin
            m_valid[i] = 0;
        end else begin
            exp_q[0] = nl;
            exp_n = 1;
            m_addr[i] = nl;
        end
        return 1;
    endfunction

    // Issue one command at a negedge, then follow the prefetch sequence.
    task automatic cmd(input bit da, input logic [LW-1:0] base, input logic [SW-1:0] s,
                       input bit dh, input logic [LW-1:0] hl, input bit x,
                       input bit inject, input string tag);
        bit exp_busy;
        int acc;
        int guard;
        bit rdy;
        cross_en = x;
        exp_busy = 0;
        if (da) begin
            m_alloc(base, s, x);
            exp_busy = 1;
        end else if (dh) begin
            exp_busy = m_hit(hl, x);
        end else begin
            exp_n = 0;
        end
        alloc_valid = da; alloc_line = base; alloc_stride = s;
        hit_valid = dh; hit_line = hl;
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 0; hit_valid = 0;
        chk(busy == exp_busy, "R8", {tag, " busy after command"}, busy, exp_busy);
        acc = 0;
        guard = 0;
        while (busy && guard < 200) begin
            if (pf_valid) begin
                if (acc < exp_n)
                    chk(pf_line == exp_q[acc], tag, "prefetch line", pf_line, exp_q[acc]);
                else
                    chk(0, tag, "extra prefetch", acc + 1, exp_n);
            end
            rdy = ($urandom % 3) != 0;
            pf_ready = rdy;
            if (pf_valid && rdy) acc++;
            if (inject) begin
                alloc_valid = 1; alloc_line = LW'($urandom % 256); alloc_stride = 8'd1;
                hit_valid = 1; hit_line = LW'($urandom % 256);
            end
            @(posedge clk);
            @(negedge clk);
            guard++;
        end
        alloc_valid = 0; hit_valid = 0; pf_ready = 0;
        chk(acc == exp_n, tag, "prefetch count", acc, exp_n);
    endtask

    task automatic probe(input logic [LW-1:0] l, input string req);
        int e;
        e = m_match(l);
        probe_line = l;
        #1;
        chk(probe_hit == (e >= 0), req, "probe_hit", probe_hit, e >= 0);
        if (e >= 0) chk(probe_idx == 2'(e), req, "probe_idx", probe_idx, e);
    endtask

    function automatic logic [LW-1:0] pick_line();
        int i;
        i = $urandom % N;
        if (m_valid[i] && ($urandom % 4) != 0)
            return m_addr[i] - LW'(($urandom % S)) * ext(m_stride[i]);
        return LW'($urandom % 256);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_addr[i] = '0; m_stride[i] = '0; m_time[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state.
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(pf_valid == 0, "R1", "pf_valid after reset", pf_valid, 0);
        probe(20'd0, "R1");
        probe(20'd1, "R1");

        // R3: four allocations fill the table, unit stride inside a page.
        cmd(1, 20'd0,   8'd1, 0, '0, 0, 0, "R3");
        chk(exp_n == 3, "R3", "startup count", exp_n, 3);
        cmd(1, 20'd32,  8'd1, 0, '0, 0, 0, "R3");
        cmd(1, 20'd64,  8'd1, 0, '0, 0, 0, "R3");
        cmd(1, 20'd128, 8'd1, 0, '0, 0, 0, "R3");
        // R6: window of the second stream is 35,34,33; 32 lies outside it.
        probe(20'd35, "R6");
        probe(20'd33, "R6");
        probe(20'd32, "R6");
        probe_line = 20'd33; #1;
        chk(probe_hit && probe_idx == 2'd1, "R6", "window member index", probe_idx, 1);

        // R5: hit on stream 1 advances it to 36.
        cmd(0, '0, '0, 1, 20'd34, 0, 0, "R5");
        chk(exp_n == 1, "R5", "one prefetch per hit", exp_n, 1);
        // R5: hit on a non-member line is ignored.
        cmd(0, '0, '0, 1, 20'd500, 0, 0, "R5");
        probe(20'd36, "R5");

        // R2: table full, the oldest (stream 0) is replaced, then stream 2.
        cmd(1, 20'd200, 8'd1, 0, '0, 0, 0, "R2");
        probe_line = 20'd201; #1;
        chk(probe_hit && probe_idx == 2'd0, "R2", "LRU victim index", probe_idx, 0);
        cmd(1, 20'd224, 8'd1, 0, '0, 0, 0, "R2");
        probe_line = 20'd225; #1;
        chk(probe_hit && probe_idx == 2'd2, "R2", "LRU victim index", probe_idx, 2);

        // R4: page stop with crossing disabled, then continuation when enabled.
        cmd(1, 20'd110, 8'd1, 0, '0, 0, 0, "R4");
        chk(exp_n == 1, "R4", "stop at page edge", exp_n, 1);
        probe(20'd111, "R4");
        cmd(1, 20'd110, 8'd1, 0, '0, 1, 0, "R4");
        chk(exp_n == 3, "R4", "cross page enabled", exp_n, 3);
        probe(20'd113, "R4");
        // R4: negative stride leaving the page downward.
        cmd(1, 20'd50, 8'hFE, 0, '0, 0, 0, "R4");
        probe(20'd48, "R4");

        // R8: commands held high during a burst are dropped.
        cmd(1, 20'd70, 8'd3, 0, '0, 1, 1, "R8");
        probe(20'd79, "R8");

        // R9: allocation and hit together, only the allocation acts.
        cmd(1, 20'd150, 8'd2, 1, 20'd225, 0, 0, "R9");
        probe(20'd226, "R9");

        // Random phase: mixed allocations, hits, probes and backpressure.
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [SW-1:0] s;
            kind = $urandom % 10;
            s = SW'(($urandom % 4) + 1);
            if ($urandom % 2) s = -s;
            if (kind < 4)
                cmd(1, LW'($urandom % 256), s, 0, '0, ($urandom % 3) == 0, ($urandom % 5) == 0, "R3");
            else if (kind < 9)
                cmd(0, '0, '0, 1, pick_line(), ($urandom % 3) == 0, ($urandom % 5) == 0, "R5");
            else
                cmd(1, LW'($urandom % 256), s, 1, pick_line(), 0, 0, "R9");
            probe(pick_line(), "R6");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule